// File: doc/BRIEF.md
# Extended-Address Wide-Data Memory Slave

This block is the bus-facing side of a small memory target on a parallel backplane bus. The address is 24 bits wide. The low 16 bits arrive on dedicated address lines. The upper byte is time-shared with the master's 8-bit outbound data lanes and is present only at the start of a cycle. The slave latches that byte on the clock where the master marks the start of a cycle. It then joins the byte with the dedicated lines and checks whether the full address lies inside a parameterised window backed by an internal RAM.

A master may ask for a 16-bit transfer by pulling an active-low width request low. If the address hits the window and wide support is enabled, the slave answers with an active-low width acknowledge. In a wide cycle the outbound lanes carry the low byte and the inbound lanes carry the high byte, in both directions. In a narrow cycle the inbound lanes only carry read data toward the master, and the outbound lanes only carry write data toward the slave. Address bit 0 selects the byte.

The slave holds its ready output low for a fixed number of clocks after every hit cycle begins, so the master inserts wait states. A bus-side reset that stays low for several consecutive clocks ends any open cycle.

Top module: `xbus_mem_slave`

## Requirements
- R1: While `rst` is high and right after it, `ack_wide_n` is 1, `rdy` is 1, `din_oe` is 0 and `dout_oe` is 0.
- R2: On the clock edge where `sync` is 1, the slave captures the address {`dout_in`, `addr_lo`}. The cycle hits only if BASE <= address < BASE + 2*DEPTH. Two addresses with equal low 16 bits but different upper bytes are told apart.
- R3: In a cycle whose address misses the window, `din_oe` and `dout_oe` stay 0, `ack_wide_n` stays 1, `rdy` stays 1, and a write strobe leaves the memory unchanged.
- R4: From the clock after `sync` until the cycle ends, `ack_wide_n` is 0 exactly when `sts_wide_n` was 0 at `sync` and the address hit. A cycle ends at the next `sync` or at a bus reset.
- R5: In a wide read with `rd_en` high, `dout_oe` and `din_oe` are both 1. `dout_drv` carries bits 7:0 of the addressed 16-bit word and `din_drv` carries bits 15:8. The word is selected by offset bits above bit 0.
- R6: In a narrow read with `rd_en` high, only `din_oe` is 1. `din_drv` carries bits 7:0 of the word when address bit 0 is 0, and bits 15:8 when it is 1.
- R7: `dout_oe` is never 1 while `rd_en` is 0, so the slave never drives the outbound lanes while they may still carry the upper address.
- R8: A write stores data on each clock with `wr_n` low and `rdy` high. A wide write stores {`din_in`, `dout_in`} into the whole word. A narrow write stores `dout_in` into only the byte selected by address bit 0 and ignores `din_in`.
- R9: A write strobe while `sts_out` is 1 does not change the memory.
- R10: In a hit cycle, `rdy` is 0 for exactly WAITS clocks after the `sync` edge and then returns to 1.
- R11: `bus_rst_n` low on RST_STATES (3) consecutive clock edges ends the open cycle: acknowledge released, no lane driven. Only 2 consecutive low edges leave the cycle open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_n | input | 1 | Bus-side reset, active low, filtered by a run-length count |
| sync | input | 1 | Start-of-cycle marker from the master |
| sts_out | input | 1 | Output-status flag; a write with it set is not a memory write |
| sts_wide_n | input | 1 | 16-bit transfer request, active low |
| rd_en | input | 1 | Read data enable from the master |
| wr_n | input | 1 | Write strobe, active low |
| addr_lo | input | 16 | Dedicated address lines, bits 15:0 |
| dout_in | input | 8 | Outbound lanes as received: upper address at start, later write low byte |
| din_in | input | 8 | Inbound lanes as received: write high byte in wide cycles |
| dout_drv | output | 8 | Value driven onto outbound lanes in wide reads |
| dout_oe | output | 1 | Drive enable for outbound lanes |
| din_drv | output | 8 | Value driven onto inbound lanes during reads |
| din_oe | output | 1 | Drive enable for inbound lanes |
| ack_wide_n | output | 1 | 16-bit acknowledge, active low |
| rdy | output | 1 | Ready; 0 asks the master for a wait state |

## Verification
Reads and writes use both widths and both values of address bit 0. A narrow write to the odd byte keeps junk on `din_in`, which separates correct lane selection from a design that merges the lanes. Accesses at the first and last words of the window, and one byte on each side of it, test the window bounds. A write whose low 16 bits match a hit but whose upper byte differs shows whether the latched upper byte is really used. A read-back after a write with `sts_out` set checks the write qualifier. Bus reset pulses of two and of three clocks show where the run-length filter draws its line.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int XADDR_W = 24;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = 2 * LANE_W;

    typedef logic [XADDR_W-1:0] xaddr_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LANE_W-1:0]  lane_byte_t;

    // State of the cycle that is currently open on the bus
    typedef struct packed {
        logic   act;       // a cycle has started and not yet ended
        logic   wide_req;  // master asked for 16 bits at cycle start
        xaddr_t addr;      // full captured address
    } xcyc_t;

    // Everything the slave puts onto the two lane groups
    typedef struct packed {
        lane_byte_t dout;
        logic       dout_oe;
        lane_byte_t din;
        logic       din_oe;
    } lane_t;

    function automatic logic in_window(input xaddr_t a, input xaddr_t base,
                                       input logic [XADDR_W:0] size);
        logic [XADDR_W:0] off;
        off = {1'b0, a} - {1'b0, base};
        return (!off[XADDR_W]) && (off < size);
    endfunction

    function automatic lane_byte_t pick_byte(input word_t w, input logic hi);
        return hi ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/xbs_capture.sv
module xbs_capture
    import xbs_pkg::*;
#(
    parameter xaddr_t BASE       = 24'h3A_0100,
    parameter int     DEPTH      = 64,
    parameter bit     WIDE_EN    = 1'b1,
    parameter int     RST_STATES = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync,
    input  logic                bus_rst_n,
    input  lane_byte_t          ext_byte,
    input  logic [15:0]         addr_lo,
    input  logic                wide_req_n,
    output xcyc_t               cyc,
    output logic                hit,
    output logic                wide,
    output logic                abort
);
    localparam int LCW = (RST_STATES > 1) ? $clog2(RST_STATES) : 1;
    localparam logic [XADDR_W:0] SIZE = (XADDR_W+1)'(2 * DEPTH);

    logic [LCW-1:0] low_run;

    // Bus reset filter: a cycle is ended only by a long enough low run
    assign abort = !bus_rst_n && (low_run == LCW'(RST_STATES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (bus_rst_n) begin
            low_run <= '0;
        end else if (!abort) begin
            low_run <= low_run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (abort) begin
            cyc.act <= 1'b0;
        end else if (sync) begin
            cyc.act      <= 1'b1;
            cyc.wide_req <= !wide_req_n;
            cyc.addr     <= {ext_byte, addr_lo};
        end
    end

    assign hit  = cyc.act && in_window(cyc.addr, BASE, SIZE);

    generate
        if (WIDE_EN) begin : g_wide
            assign wide = hit && cyc.wide_req;
        end else begin : g_narrow
            assign wide = 1'b0;
        end
    endgenerate

    // R2: the captured address is the multiplexed byte joined with the low lines
    p_ext_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (sync && !abort) |=> (cyc.addr == {$past(ext_byte), $past(addr_lo)}));

    // R11: a completed low run leaves no open cycle
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
        abort |=> !cyc.act);

endmodule

// File: rtl/xbs_wait.sv
module xbs_wait #(
    parameter int WAITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic abort,
    input  logic active,
    output logic rdy
);
    generate
        if (WAITS == 0) begin : g_nowait
            assign rdy = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(WAITS + 1);
            logic [CW-1:0] left;

            always_ff @(posedge clk) begin
                if (rst || abort) begin
                    left <= '0;
                end else if (load) begin
                    left <= CW'(WAITS);
                end else if (left != '0) begin
                    left <= left - 1'b1;
                end
            end

            assign rdy = !(active && (left != '0));

            // R10: each clock of an unfinished wait burns exactly one state
            p_wait_step_r10: assert property (@(posedge clk) disable iff (rst)
                (left != '0 && !load && !abort) |=> (left == $past(left) - 1'b1));
        end
    endgenerate
endmodule

// File: rtl/xbs_store.sv
module xbs_store
    import xbs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic [1:0]      we,
    input  logic [IDXW-1:0] idx,
    input  word_t           wdata,
    output word_t           rdata
);
    generate
        for (genvar g = 0; g < 2; g++) begin : g_bank
            lane_byte_t bank [DEPTH];

            always_ff @(posedge clk) begin
                if (we[g]) begin
                    bank[idx] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            assign rdata[g*LANE_W +: LANE_W] = bank[idx];
        end
    endgenerate
endmodule

// File: rtl/xbs_lanes.sv
module xbs_lanes
    import xbs_pkg::*;
(
    input  logic  rd_go,
    input  logic  wide,
    input  logic  hi_sel,
    input  word_t rdata,
    output lane_t lane
);
    always_comb begin
        lane         = '0;
        lane.din_oe  = rd_go;
        lane.dout_oe = rd_go && wide;
        if (rd_go) begin
            if (wide) begin
                lane.dout = rdata[LANE_W-1:0];
                lane.din  = rdata[WORD_W-1:LANE_W];
            end else begin
                lane.din  = pick_byte(rdata, hi_sel);
            end
        end
    end
endmodule

// File: rtl/xbus_mem_slave.sv
module xbus_mem_slave
    import xbs_pkg::*;
#(
    parameter logic [23:0] BASE       = 24'h3A_0100,
    parameter int          DEPTH      = 64,
    parameter bit          WIDE_EN    = 1'b1,
    parameter int          WAITS      = 2,
    parameter int          RST_STATES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rst_n,
    input  logic        sync,
    input  logic        sts_out,
    input  logic        sts_wide_n,
    input  logic        rd_en,
    input  logic        wr_n,
    input  logic [15:0] addr_lo,
    input  logic [7:0]  dout_in,
    input  logic [7:0]  din_in,
    output logic [7:0]  dout_drv,
    output logic        dout_oe,
    output logic [7:0]  din_drv,
    output logic        din_oe,
    output logic        ack_wide_n,
    output logic        rdy
);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    xcyc_t           cyc;
    logic            hit;
    logic            wide;
    logic            abort;
    logic            rd_go;
    logic            wr_go;
    logic [1:0]      we;
    xaddr_t          off;
    logic [IDXW-1:0] idx;
    word_t           wdata;
    word_t           rdata;
    lane_t           lane;

    xbs_capture #(
        .BASE(BASE), .DEPTH(DEPTH), .WIDE_EN(WIDE_EN), .RST_STATES(RST_STATES)
    ) u_cap (
        .clk(clk), .rst(rst), .sync(sync), .bus_rst_n(bus_rst_n),
        .ext_byte(dout_in), .addr_lo(addr_lo), .wide_req_n(sts_wide_n),
        .cyc(cyc), .hit(hit), .wide(wide), .abort(abort)
    );

    xbs_wait #(.WAITS(WAITS)) u_wait (
        .clk(clk), .rst(rst), .load(sync), .abort(abort),
        .active(hit), .rdy(rdy)
    );

    assign off   = cyc.addr - BASE;
    assign idx   = off[IDXW:1];
    assign rd_go = hit && rd_en && rdy;
    assign wr_go = hit && !wr_n && !sts_out && rdy;
    assign we[0] = wr_go && (wide || !cyc.addr[0]);
    assign we[1] = wr_go && (wide || cyc.addr[0]);
    // Narrow writes only ever see the outbound lanes; copy them to both halves
    assign wdata = wide ? {din_in, dout_in} : {dout_in, dout_in};

    xbs_store #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(we), .idx(idx), .wdata(wdata), .rdata(rdata)
    );

    xbs_lanes u_lanes (
        .rd_go(rd_go), .wide(wide), .hi_sel(cyc.addr[0]),
        .rdata(rdata), .lane(lane)
    );

    assign dout_drv   = lane.dout;
    assign dout_oe    = lane.dout_oe;
    assign din_drv    = lane.din;
    assign din_oe     = lane.din_oe;
    assign ack_wide_n = !wide;

    // R7: the outbound lanes are only driven during an enabled read
    p_dout_after_rd_r7: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> rd_en);

    // R3: an open cycle that missed the window leaves every bus output quiet
    p_quiet_on_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc.act && !hit) |-> (!din_oe && !dout_oe && ack_wide_n && rdy));

    // R9: output-status cycles never reach the storage
    p_io_write_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        sts_out |-> (we == 2'b00));

    // R4: no acknowledge follows a cycle start without a width request
    p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
        (sync && sts_wide_n && bus_rst_n) |=> ack_wide_n);

endmodule

// File: tb/sim_xbus_mem_slave.sv
module sim_xbus_mem_slave;

    localparam logic [23:0] BASE  = 24'h3A_0100;
    localparam int          DEPTH = 64;
    localparam int          WAITS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst_n = 1'b1;
    logic       sync = 1'b0;
    logic       sts_out = 1'b0;
    logic       sts_wide_n = 1'b1;
    logic       rd_en = 1'b0;
    logic       wr_n = 1'b1;
    logic [15:0] addr_lo = '0;
    logic [7:0] dout_in = '0;
    logic [7:0] din_in = '0;
    logic [7:0] dout_drv;
    logic       dout_oe;
    logic [7:0] din_drv;
    logic       din_oe;
    logic       ack_wide_n;
    logic       rdy;

    int checks = 0;
    int errors = 0;

    logic [15:0] ref_mem [DEPTH];

    // scoreboard: {din_oe, din, dout_oe, dout}
    logic [17:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    xbus_mem_slave #(.BASE(BASE), .DEPTH(DEPTH), .WAITS(WAITS)) u0 (
        .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .sync(sync),
        .sts_out(sts_out), .sts_wide_n(sts_wide_n), .rd_en(rd_en), .wr_n(wr_n),
        .addr_lo(addr_lo), .dout_in(dout_in), .din_in(din_in),
        .dout_drv(dout_drv), .dout_oe(dout_oe), .din_drv(din_drv),
        .din_oe(din_oe), .ack_wide_n(ack_wide_n), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic hits(input logic [23:0] a);
        return (a >= BASE) && ((a - BASE) < 24'(2 * DEPTH));
    endfunction

    // Monitor: every enabled read clock consumes one expected lane picture
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 read with no expectation actual=%0h expected=none",
                         {din_oe, din_drv, dout_oe, dout_drv});
            end else begin
                logic [17:0] e;
                string       t;
                logic [17:0] a;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {din_oe, (din_oe ? din_drv : 8'h00), dout_oe, (dout_oe ? dout_drv : 8'h00)};
                chk(t, 32'(a), 32'(e));
            end
        end
    end

    // One complete bus cycle; expectations come from the requirements
    task automatic bus_cycle(input logic [23:0] a, input logic wide_req,
                             input logic is_wr, input logic io,
                             input logic [15:0] wd, input string tag);
        logic h;
        logic w;
        int   n;
        int   wi;
        h  = hits(a);
        w  = h && wide_req;
        wi = int'((a - BASE) >> 1);
        @(posedge clk); #1;
        sync = 1'b1; addr_lo = a[15:0]; dout_in = a[23:16];
        sts_wide_n = !wide_req; sts_out = io;
        @(posedge clk); #1;
        sync = 1'b0; dout_in = 8'h00;
        @(negedge clk);
        chk({"R4 ack ", tag}, 32'(ack_wide_n), 32'(!w));
        n = 0;
        while (rdy == 1'b0 && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk({"R10 wait count ", tag}, 32'(n), h ? 32'(WAITS) : 32'd0);
        chk({"R7 no early drive ", tag}, 32'({dout_oe, din_oe}), 32'd0);
        if (is_wr) begin
            @(posedge clk); #1;
            wr_n = 1'b0; dout_in = wd[7:0]; din_in = wd[15:8];
            @(posedge clk); #1;
            wr_n = 1'b1; dout_in = 8'h00; din_in = 8'h00;
            if (h && !io) begin
                if (w) ref_mem[wi] = wd;
                else if (a[0]) ref_mem[wi][15:8] = wd[7:0];
                else ref_mem[wi][7:0] = wd[7:0];
            end
        end else begin
            logic [17:0] e;
            if (!h) e = '0;
            else if (w) e = {1'b1, ref_mem[wi][15:8], 1'b1, ref_mem[wi][7:0]};
            else e = {1'b1, (a[0] ? ref_mem[wi][15:8] : ref_mem[wi][7:0]), 1'b0, 8'h00};
            exp_q.push_back(e);
            tag_q.push_back(tag);
            @(posedge clk); #1;
            rd_en = 1'b1;
            @(posedge clk); #1;
            rd_en = 1'b0;
        end
        @(negedge clk);
        chk({"R4 ack held ", tag}, 32'(ack_wide_n), 32'(!w));
        sts_out = 1'b0; sts_wide_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ack after reset", 32'(ack_wide_n), 32'd1);
        chk("R1 rdy after reset", 32'(rdy), 32'd1);
        chk("R1 din_oe after reset", 32'(din_oe), 32'd0);
        chk("R1 dout_oe after reset", 32'(dout_oe), 32'd0);
        @(posedge clk); #1 rst = 1'b0;

        // Fill words 0, 1 and the last word (R8)
        bus_cycle(24'h3A_0100, 1'b1, 1'b1, 1'b0, 16'hA55A, "R8 wide write");
        bus_cycle(24'h3A_0102, 1'b0, 1'b1, 1'b0, 16'hCC11, "R8 narrow even");
        bus_cycle(24'h3A_0103, 1'b0, 1'b1, 1'b0, 16'hCC22, "R8 narrow odd");
        bus_cycle(24'h3A_017E, 1'b1, 1'b1, 1'b0, 16'hBEEF, "R8 last word");

        bus_cycle(24'h3A_0100, 1'b1, 1'b0, 1'b0, 16'h0, "R5 wide read w0");
        bus_cycle(24'h3A_0100, 1'b0, 1'b0, 1'b0, 16'h0, "R6 narrow even w0");
        bus_cycle(24'h3A_0101, 1'b0, 1'b0, 1'b0, 16'h0, "R6 narrow odd w0");
        bus_cycle(24'h3A_0103, 1'b0, 1'b0, 1'b0, 16'h0, "R6 R8 narrow odd w1");
        bus_cycle(24'h3A_0102, 1'b1, 1'b0, 1'b0, 16'h0, "R5 R8 wide read w1");
        bus_cycle(24'h3A_017E, 1'b1, 1'b0, 1'b0, 16'h0, "R5 last word");

        // Narrow odd write with junk on din_in must keep the low byte (R8)
        bus_cycle(24'h3A_0101, 1'b0, 1'b1, 1'b0, 16'hCC77, "R8 odd keeps low");
        bus_cycle(24'h3A_0100, 1'b1, 1'b0, 1'b0, 16'h0, "R8 read after odd");

        // Output-status write must not land (R9)
        bus_cycle(24'h3A_0100, 1'b1, 1'b1, 1'b1, 16'hFFFF, "R9 io write");
        bus_cycle(24'h3A_0100, 1'b1, 1'b0, 1'b0, 16'h0, "R9 read back");

        // Window edges and upper-byte decode (R2, R3)
        bus_cycle(24'h3B_0100, 1'b1, 1'b0, 1'b0, 16'h0, "R2 R3 other upper byte");
        bus_cycle(24'h3A_0180, 1'b1, 1'b0, 1'b0, 16'h0, "R3 past top");
        bus_cycle(24'h3A_00FF, 1'b0, 1'b0, 1'b0, 16'h0, "R3 below base");
        bus_cycle(24'h3B_0100, 1'b1, 1'b1, 1'b0, 16'h0000, "R2 R3 miss write");
        bus_cycle(24'h3A_0100, 1'b1, 1'b0, 1'b0, 16'h0, "R2 after miss write");

        // Bus reset filter (R11)
        @(posedge clk); #1;
        sync = 1'b1; addr_lo = 16'h0100; dout_in = 8'h3A; sts_wide_n = 1'b0;
        @(posedge clk); #1;
        sync = 1'b0; dout_in = 8'h00;
        repeat (WAITS + 1) @(posedge clk);
        #1 bus_rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 bus_rst_n = 1'b1;
        @(negedge clk);
        chk("R11 two low clocks keep cycle", 32'(ack_wide_n), 32'd0);
        @(posedge clk); #1 bus_rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 bus_rst_n = 1'b1;
        @(negedge clk);
        chk("R11 three low clocks end ack", 32'(ack_wide_n), 32'd1);
        chk("R11 rdy after bus reset", 32'(rdy), 32'd1);
        exp_q.push_back(18'h0);
        tag_q.push_back("R11 no drive after bus reset");
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        sts_wide_n = 1'b1;
        repeat (3) @(posedge clk);
        chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule